// File: doc/BRIEF.md
# Powerline Packet Transmit Handshake Sequencer

This block is the transmit-side controller between a host processor and a symbol-level line modulator. The host drives two write strobes. One loads a single-byte transmit buffer. The other presents an 8-bit command code. The block answers through an 8-bit confirm register and a one-cycle handshake interrupt, and it reports the medium state it is requesting.

While idle, the block marks every unit symbol time (UST) with an interrupt that says whether the line is quiet or active. A start command arms it. The preamble then begins on the next UST boundary, counted from the last idle or resync command. Control and data bytes pass one at a time through the buffer. The block raises an interrupt each time a buffered byte is handed to the modulator. A byte flagged as last is followed by an end-of-packet symbol and a CRC-16 over all the bytes, and these two steps raise no interrupt. A final interrupt closes the packet. The block then waits for the host's idle command.

The modulator is modelled as a symbol-accepting interface. The block issues one launch pulse with a symbol kind and a payload, and the modulator returns a done pulse when that symbol has left the line. If the buffer is empty when a byte is needed, or the continue command is missing after the last byte, the packet is aborted and an error code is reported.

Top module: `plx_tx_sequencer`

## Requirements
- R1: In idle, an interrupt is raised exactly UST_CYCLES clock cycles after a 0x00 or 0x20 command, and every UST_CYCLES cycles after that. The confirm code is 0x01 when `line_busy` is low and 0x02 when it is high.
- R2: Command 0xA6 arms a packet, and 0xB6 arms one with the suppression flag. Bit 4 of every command is the leading-zero-suppression flag. The preamble launch (`mod_sym` = 0) occurs only at a UST boundary and carries bit 4 of the start command on `mod_lzs`.
- R3: At the preamble launch, the interrupt fires and the confirm code becomes 0x10.
- R4: A byte committed by 0xA2 or 0xB2 before the preamble's done pulse is launched at that done pulse. The launch has `mod_sym` = 1, the byte in the low bits of `mod_data`, and the command's bit 4 on `mod_lzs`.
- R5: The buffer holds one byte. Every byte launch raises the interrupt with confirm 0x10 and empties the buffer for the next commit.
- R6: Command 0xA4 or 0xB4 commits the last byte. After that byte launches, the host must send 0xA0. The done pulse of that byte then launches the end-of-packet symbol (`mod_sym` = 2) with no interrupt.
- R7: The done pulse of the end-of-packet symbol launches the CRC (`mod_sym` = 3) with no interrupt. The CRC is CRC-16, polynomial 0x1021, preset 0xFFFF, MSB first, over every launched byte. The CRC's done pulse raises the final interrupt with confirm 0x40.
- R8: After the final interrupt, no interrupt occurs until the host writes 0x00. From that write, the idle UST interrupts of R1 resume.
- R9: A done pulse that finds the buffer empty, or that ends the last byte without a prior 0xA0, aborts the packet. It raises the interrupt with confirm 0x80, launches nothing, returns to idle, and sets the medium state to 0.
- R10: `med_st` is 0 (inferior) outside a packet, 1 (superior phase 1) from the preamble launch, and 2 (superior phase 2) from the first byte launch until the final or abort interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_stb | input | 1 | Command write strobe |
| req_code | input | 8 | Command code |
| txb_stb | input | 1 | Transmit buffer write strobe |
| txb_data | input | DATA_W | Transmit buffer byte |
| line_busy | input | 1 | Line activity seen by the receiver |
| mod_done | input | 1 | Modulator finished the current symbol |
| irq | output | 1 | Handshake interrupt pulse |
| cfm | output | 8 | Confirm status code |
| med_st | output | 2 | Requested medium state |
| mod_go | output | 1 | Symbol launch pulse |
| mod_sym | output | 2 | Symbol kind: 0 preamble, 1 byte, 2 end of packet, 3 CRC |
| mod_data | output | CRC_W | Byte or CRC payload |
| mod_lzs | output | 1 | Leading-zero suppression for this symbol |

## Verification
The hardest states to reach are the two deadline failures. One is a preamble that ends before the first byte was committed. The other is a last byte that ends without the continue command. The stimulus reaches them by holding back the commit or the 0xA0 write before pulsing the modulator's done input. Start alignment is the other subtle point. The bench waits a random number of cycles after an idle tick before arming, then confirms that the preamble still lands on the boundary set by the last 0x00 or 0x20. Packets of random length, data and suppression flags are compared against a CRC computed in the bench.

// File: rtl/plx_pkg.sv
package plx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ARM, ST_PRE, ST_BODY, ST_EOP, ST_CRC, ST_HOLD
   } plx_state_t;

   typedef enum logic [1:0] {
      SYM_PRE  = 2'd0,
      SYM_BYTE = 2'd1,
      SYM_EOP  = 2'd2,
      SYM_CRC  = 2'd3
   } plx_sym_t;

   typedef enum logic [1:0] {
      MED_INFERIOR = 2'd0,
      MED_SUP_ONE  = 2'd1,
      MED_SUP_TWO  = 2'd2
   } plx_med_t;

   // command codes; bit 4 carries leading-zero suppression
   localparam logic [7:0] OP_LZS_BIT = 8'h10;
   localparam logic [7:0] OP_START   = 8'hA6;
   localparam logic [7:0] OP_DATA    = 8'hA2;
   localparam logic [7:0] OP_LAST    = 8'hA4;
   localparam logic [7:0] OP_CONT    = 8'hA0;
   localparam logic [7:0] OP_IDLE    = 8'h00;
   localparam logic [7:0] OP_RESYNC  = 8'h20;

   // confirm codes
   localparam logic [7:0] CFM_QUIET    = 8'h01;
   localparam logic [7:0] CFM_ACTIVE   = 8'h02;
   localparam logic [7:0] CFM_READY    = 8'h10;
   localparam logic [7:0] CFM_DONE     = 8'h40;
   localparam logic [7:0] CFM_UNDERRUN = 8'h80;

endpackage

// File: rtl/plx_ust_timer.sv
module plx_ust_timer #(
   parameter int UST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic resync,
   output logic tick
);
   localparam int CNT_W = (UST_CYCLES > 2) ? $clog2(UST_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UST_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   assign tick = (cnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (resync || tick)   cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end

   // boundaries are never adjacent; a resync restarts the interval
   assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   assert_resync_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> !tick);

endmodule

// File: rtl/plx_crc_acc.sv
module plx_crc_acc #(
   parameter int              DATA_W    = 8,
   parameter int              CRC_W     = 16,
   parameter logic [CRC_W-1:0] POLY     = 16'h1021,
   parameter logic [CRC_W-1:0] INIT     = 16'hFFFF,
   parameter bit              LSB_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [CRC_W-1:0]  crc
);
   logic [CRC_W-1:0] crc_q, crc_nxt;

   if (LSB_FIRST) begin : g_lsb
      logic [CRC_W-1:0] poly_rev;
      always_comb begin
         for (int k = 0; k < CRC_W; k++) poly_rev[k] = POLY[CRC_W-1-k];
      end
      always_comb begin
         logic [CRC_W-1:0] c;
         logic fb;
         c = crc_q;
         for (int i = 0; i < DATA_W; i++) begin
            fb = c[0] ^ din[i];
            c  = c >> 1;
            if (fb) c = c ^ poly_rev;
         end
         crc_nxt = c;
      end
   end else begin : g_msb
      always_comb begin
         logic [CRC_W-1:0] c;
         logic fb;
         c = crc_q;
         for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ din[i];
            c  = c << 1;
            if (fb) c = c ^ POLY;
         end
         crc_nxt = c;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= INIT;
      else if (init)  crc_q <= INIT;
      else if (load)  crc_q <= crc_nxt;
   end

   assign crc = crc_q;

   assert_crc_preset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> crc == INIT);
   assert_crc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!init && !load) |=> $stable(crc));

endmodule

// File: rtl/plx_tx_fsm.sv
module plx_tx_fsm
   import plx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CRC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_stb,
   input  logic [7:0]        req_code,
   input  logic              txb_stb,
   input  logic [DATA_W-1:0] txb_data,
   input  logic              line_busy,
   input  logic              mod_done,
   input  logic              ust_tick,
   input  logic [CRC_W-1:0]  crc_val,
   output logic              ust_resync,
   output logic              crc_init,
   output logic              crc_load,
   output logic [DATA_W-1:0] crc_din,
   output logic              irq,
   output logic [7:0]        cfm,
   output logic [1:0]        med_st,
   output logic              mod_go,
   output logic [1:0]        mod_sym,
   output logic [CRC_W-1:0]  mod_data,
   output logic              mod_lzs
);
   plx_state_t        st_q;
   logic [DATA_W-1:0] buf_q;
   logic              buf_full, buf_lzs, buf_last;
   logic              tail_seen, cur_last, cont_ok, start_lzs;

   logic [7:0] op_base;
   logic       op_lzs, want_start, want_commit, want_cont, want_idle;
   logic       in_pkt, commit_ok, launch, close_ok;

   always_comb begin
      op_base     = req_code & ~OP_LZS_BIT;
      op_lzs      = |(req_code & OP_LZS_BIT);
      want_start  = req_stb && (op_base == OP_START);
      want_commit = req_stb && ((op_base == OP_DATA) || (op_base == OP_LAST));
      want_cont   = req_stb && (req_code == OP_CONT);
      want_idle   = req_stb && (req_code == OP_IDLE);
      ust_resync  = req_stb && ((req_code == OP_IDLE) || (req_code == OP_RESYNC));
      in_pkt      = (st_q == ST_PRE) || (st_q == ST_BODY);
      commit_ok   = want_commit && in_pkt && !buf_full && !tail_seen;
      launch      = mod_done && buf_full &&
                    ((st_q == ST_PRE) || ((st_q == ST_BODY) && !cur_last));
      close_ok    = mod_done && (st_q == ST_BODY) && cur_last && cont_ok;
      crc_init    = (st_q == ST_IDLE) && want_start;
      crc_load    = launch;
      crc_din     = buf_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         buf_q     <= '0;
         buf_full  <= 1'b0;
         buf_lzs   <= 1'b0;
         buf_last  <= 1'b0;
         tail_seen <= 1'b0;
         cur_last  <= 1'b0;
         cont_ok   <= 1'b0;
         start_lzs <= 1'b0;
         irq       <= 1'b0;
         cfm       <= '0;
         med_st    <= MED_INFERIOR;
         mod_go    <= 1'b0;
         mod_sym   <= SYM_PRE;
         mod_data  <= '0;
         mod_lzs   <= 1'b0;
      end else begin
         irq    <= 1'b0;
         mod_go <= 1'b0;
         if (txb_stb) buf_q <= txb_data;
         if (commit_ok) begin
            buf_full  <= 1'b1;
            buf_lzs   <= op_lzs;
            buf_last  <= (op_base == OP_LAST);
            tail_seen <= tail_seen | (op_base == OP_LAST);
         end
         if (want_cont && (st_q == ST_BODY) && cur_last) cont_ok <= 1'b1;

         unique case (st_q)
            ST_IDLE: begin
               if (ust_tick) begin
                  irq <= 1'b1;
                  cfm <= line_busy ? CFM_ACTIVE : CFM_QUIET;
               end
               if (want_start) begin
                  st_q      <= ST_ARM;
                  start_lzs <= op_lzs;
                  buf_full  <= 1'b0;
                  tail_seen <= 1'b0;
                  cur_last  <= 1'b0;
                  cont_ok   <= 1'b0;
               end
            end
            ST_ARM: begin
               if (ust_tick) begin
                  mod_go   <= 1'b1;
                  mod_sym  <= SYM_PRE;
                  mod_data <= '0;
                  mod_lzs  <= start_lzs;
                  irq      <= 1'b1;
                  cfm      <= CFM_READY;
                  med_st   <= MED_SUP_ONE;
                  st_q     <= ST_PRE;
               end
            end
            ST_PRE, ST_BODY: begin
               if (launch) begin
                  mod_go   <= 1'b1;
                  mod_sym  <= SYM_BYTE;
                  mod_data <= CRC_W'(buf_q);
                  mod_lzs  <= buf_lzs;
                  irq      <= 1'b1;
                  cfm      <= CFM_READY;
                  med_st   <= MED_SUP_TWO;
                  cur_last <= buf_last;
                  buf_full <= 1'b0;
                  st_q     <= ST_BODY;
               end else if (close_ok) begin
                  mod_go   <= 1'b1;
                  mod_sym  <= SYM_EOP;
                  mod_data <= '0;
                  mod_lzs  <= 1'b0;
                  st_q     <= ST_EOP;
               end else if (mod_done) begin
                  irq      <= 1'b1;
                  cfm      <= CFM_UNDERRUN;
                  med_st   <= MED_INFERIOR;
                  buf_full <= 1'b0;
                  st_q     <= ST_IDLE;
               end
            end
            ST_EOP: begin
               if (mod_done) begin
                  mod_go   <= 1'b1;
                  mod_sym  <= SYM_CRC;
                  mod_data <= crc_val;
                  mod_lzs  <= 1'b0;
                  st_q     <= ST_CRC;
               end
            end
            ST_CRC: begin
               if (mod_done) begin
                  irq    <= 1'b1;
                  cfm    <= CFM_DONE;
                  med_st <= MED_INFERIOR;
                  st_q   <= ST_HOLD;
               end
            end
            ST_HOLD: begin
               if (want_idle) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // preamble only leaves on a UST boundary
   assert_pre_on_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_go && mod_sym == SYM_PRE) |-> $past(ust_tick));
   // each byte launch hands the buffer back with a ready interrupt
   assert_byte_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_go && mod_sym == SYM_BYTE) |-> (irq && cfm == CFM_READY && !buf_full));
   // packet tail is silent
   assert_silent_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_go && (mod_sym == SYM_EOP || mod_sym == SYM_CRC)) |-> !irq);
   // held after the final interrupt, no interrupts
   assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HOLD && $past(st_q) == ST_HOLD) |-> !irq);
   // a done pulse with nothing to send aborts the packet
   assert_underrun_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_done && in_pkt && !launch && !close_ok) |=>
         (irq && cfm == CFM_UNDERRUN && !mod_go && st_q == ST_IDLE));
   assert_med_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      med_st != 2'd3);

endmodule

// File: rtl/plx_tx_sequencer.sv
module plx_tx_sequencer #(
   parameter int              UST_CYCLES    = 16,
   parameter int              DATA_W        = 8,
   parameter int              CRC_W         = 16,
   parameter logic [CRC_W-1:0] CRC_POLY     = 16'h1021,
   parameter logic [CRC_W-1:0] CRC_INIT     = 16'hFFFF,
   parameter bit              CRC_LSB_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_stb,
   input  logic [7:0]        req_code,
   input  logic              txb_stb,
   input  logic [DATA_W-1:0] txb_data,
   input  logic              line_busy,
   input  logic              mod_done,
   output logic              irq,
   output logic [7:0]        cfm,
   output logic [1:0]        med_st,
   output logic              mod_go,
   output logic [1:0]        mod_sym,
   output logic [CRC_W-1:0]  mod_data,
   output logic              mod_lzs
);
   if (UST_CYCLES < 4) begin : g_bad_ust
      $error("UST_CYCLES must be at least 4");
   end
   if (DATA_W < 1 || CRC_W < DATA_W) begin : g_bad_width
      $error("CRC_W must be at least DATA_W, and DATA_W positive");
   end

   logic              ust_tick, ust_resync, crc_init, crc_load;
   logic [DATA_W-1:0] crc_din;
   logic [CRC_W-1:0]  crc_val;

   plx_ust_timer #(.UST_CYCLES(UST_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .resync (ust_resync),
      .tick   (ust_tick)
   );

   plx_crc_acc #(
      .DATA_W    (DATA_W),
      .CRC_W     (CRC_W),
      .POLY      (CRC_POLY),
      .INIT      (CRC_INIT),
      .LSB_FIRST (CRC_LSB_FIRST)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (crc_init),
      .load  (crc_load),
      .din   (crc_din),
      .crc   (crc_val)
   );

   plx_tx_fsm #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_stb    (req_stb),
      .req_code   (req_code),
      .txb_stb    (txb_stb),
      .txb_data   (txb_data),
      .line_busy  (line_busy),
      .mod_done   (mod_done),
      .ust_tick   (ust_tick),
      .crc_val    (crc_val),
      .ust_resync (ust_resync),
      .crc_init   (crc_init),
      .crc_load   (crc_load),
      .crc_din    (crc_din),
      .irq        (irq),
      .cfm        (cfm),
      .med_st     (med_st),
      .mod_go     (mod_go),
      .mod_sym    (mod_sym),
      .mod_data   (mod_data),
      .mod_lzs    (mod_lzs)
   );

endmodule

// File: tb/sim_plx_tx_sequencer.sv
`timescale 1ns/1ps
module sim_plx_tx_sequencer;
   localparam int UST = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_stb = 1'b0;
   logic [7:0]  req_code = '0;
   logic        txb_stb = 1'b0;
   logic [7:0]  txb_data = '0;
   logic        line_busy = 1'b0;
   logic        mod_done = 1'b0;
   logic        irq, mod_go, mod_lzs;
   logic [7:0]  cfm;
   logic [1:0]  med_st, mod_sym;
   logic [15:0] mod_data;

   int nvec = 0;
   int nbad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   plx_tx_sequencer #(.UST_CYCLES(UST)) u0 (
      .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .req_code(req_code),
      .txb_stb(txb_stb), .txb_data(txb_data), .line_busy(line_busy),
      .mod_done(mod_done), .irq(irq), .cfm(cfm), .med_st(med_st),
      .mod_go(mod_go), .mod_sym(mod_sym), .mod_data(mod_data), .mod_lzs(mod_lzs)
   );

   function automatic logic [15:0] crc_byte(input logic [15:0] c_in, input logic [7:0] d);
      logic [15:0] c;
      c = c_in;
      for (int i = 7; i >= 0; i--) begin
         if (c[15] ^ d[i]) c = (c << 1) ^ 16'h1021;
         else              c = c << 1;
      end
      return c;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic send_req(input logic [7:0] c);
      req_code = c; req_stb = 1'b1;
      cyc();
      req_stb = 1'b0;
   endtask

   task automatic send_buf(input logic [7:0] d);
      txb_data = d; txb_stb = 1'b1;
      cyc();
      txb_stb = 1'b0;
   endtask

   task automatic done_pulse();
      mod_done = 1'b1;
      cyc();
      mod_done = 1'b0;
   endtask

   task automatic chk_abort();
      chk("R9 abort irq", irq, 1);
      chk("R9 abort code", cfm, 8'h80);
      chk("R9 abort no launch", mod_go, 0);
      chk("R10 abort medium", med_st, 0);
   endtask

   // one packet; miss_at = byte index left uncommitted (-1 none)
   task automatic run_pkt(input int n, input int miss_at, input bit skip_cont, input bit use20);
      logic [15:0] crc;
      logic [7:0]  b;
      bit          busy, lz, bl, last;
      int          d, cnt;
      busy = bit'($urandom % 2);
      line_busy = busy;
      send_req(use20 ? 8'h20 : 8'h00);
      cnt = 0;
      for (int j = 1; j < UST; j++) begin cyc(); cnt += int'(irq); end
      chk("R1 R8 no irq inside first UST", cnt, 0);
      cyc();
      chk("R1 R8 idle irq on UST", irq, 1);
      chk("R1 idle status", cfm, busy ? 8'h02 : 8'h01);
      chk("R10 idle medium", med_st, 0);
      d = int'($urandom_range(0, UST - 3));
      repeat (d) cyc();
      lz = bit'($urandom % 2);
      send_req(8'hA6 | {3'b000, lz, 4'h0});
      cnt = 0;
      for (int j = 0; j < UST - 2 - d; j++) begin cyc(); cnt += int'(mod_go) + int'(irq); end
      chk("R2 no launch before boundary", cnt, 0);
      cyc();
      chk("R2 preamble launch", {mod_go, mod_sym}, {1'b1, 2'd0});
      chk("R2 preamble lzs", mod_lzs, lz);
      chk("R3 preamble irq", irq, 1);
      chk("R3 ready code", cfm, 8'h10);
      chk("R10 phase one", med_st, 1);
      crc = 16'hFFFF;
      b = '0;
      for (int i = 0; i < n; i++) begin
         last = (i == n - 1);
         if (i != miss_at) begin
            b  = 8'($urandom);
            bl = bit'($urandom % 2);
            send_buf(b);
            send_req((last ? 8'hA4 : 8'hA2) | {3'b000, bl, 4'h0});
         end
         repeat ($urandom % 3) cyc();
         done_pulse();
         if (i == miss_at) begin chk_abort(); return; end
         crc = crc_byte(crc, b);
         chk("R4 byte launch", {mod_go, mod_sym}, {1'b1, 2'd1});
         chk("R4 byte payload", mod_data, {8'h00, b});
         chk("R4 byte lzs", mod_lzs, bl);
         chk("R5 byte irq", irq, 1);
         chk("R5 ready code", cfm, 8'h10);
         chk("R10 phase two", med_st, 2);
      end
      repeat ($urandom % 3) cyc();
      if (skip_cont) begin
         done_pulse();
         chk_abort();
         return;
      end
      send_req(8'hA0);
      repeat ($urandom % 3) cyc();
      done_pulse();
      chk("R6 end symbol launch", {mod_go, mod_sym}, {1'b1, 2'd2});
      chk("R6 no irq at end symbol", irq, 0);
      done_pulse();
      chk("R7 crc launch", {mod_go, mod_sym}, {1'b1, 2'd3});
      chk("R7 crc value", mod_data, crc);
      chk("R7 no irq at crc", irq, 0);
      done_pulse();
      chk("R7 final irq", irq, 1);
      chk("R7 done code", cfm, 8'h40);
      chk("R7 nothing launched", mod_go, 0);
      chk("R10 back to inferior", med_st, 0);
      cnt = 0;
      repeat (2 * UST) begin cyc(); cnt += int'(irq); end
      chk("R8 held silent", cnt, 0);
   endtask

   initial begin
      bit prev_ok;
      int n, miss;
      bit skip;
      void'($urandom(32'd5117));
      repeat (3) cyc();
      chk("R10 reset medium", med_st, 0);
      chk("R9 reset irq", irq, 0);
      chk("R3 reset code", cfm, 8'h00);
      chk("R4 reset launch", mod_go, 0);
      rst_n = 1'b1;
      cyc();
      // directed corners
      run_pkt(1, -1, 1'b0, 1'b0);
      run_pkt(3, 0, 1'b0, 1'b0);   // first byte misses the preamble deadline
      run_pkt(2, -1, 1'b1, 1'b1);  // no continue after last byte
      run_pkt(4, 2, 1'b0, 1'b1);   // mid-packet underrun
      prev_ok = 1'b0;
      for (int p = 0; p < 40; p++) begin
         n    = 1 + int'($urandom % 6);
         miss = (($urandom % 8) == 0) ? int'($urandom % n) : -1;
         skip = (($urandom % 8) == 0);
         run_pkt(n, miss, skip, !prev_ok && bit'($urandom % 2));
         prev_ok = (miss < 0) && !skip;
      end
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         nvec++;
         nbad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

endmodule